// File: doc/BRIEF.md
# Floating-Point Format Converter Through a Single-Precision Hub

This block converts one floating-point element per transfer between storage formats: bfloat16, IEEE half, IEEE single, and four 8-bit layouts with 2, 3, 4 or 5 exponent bits. No converter exists for any pair of formats. Every element is first widened exactly to single precision and then narrowed to the requested target, so a bfloat16 to half conversion takes two hops. Narrowing rounds to nearest with ties to even. Values too large for the target saturate to its largest finite magnitude instead of wrapping.

The element enters in the low bits of a 32-bit word, along with a source format code and a destination format code. The converted element comes out zero-extended in the low bits of a 32-bit word. The converter is a two-register pipeline with a valid/ready handshake on each side. It accepts one element per cycle and stalls cleanly when the consumer holds back.

Top module: `fpx_convert`

## Requirements
- R1: Format codes are 0x06 bfloat16 (8 exponent, 7 fraction bits), 0x07 half (5, 10), 0x0A single (8, 23), 0x0D 8-bit with 3 exponent bits, 0x0E 8-bit with 4, 0x0F 8-bit with 5, and 0x11 8-bit with 2. In each 8-bit layout the fraction width is 7 minus the exponent width. Every format uses an exponent bias of 2^(E-1)-1. The 8-bit layouts reserve no exponent code: an all-ones exponent is an ordinary finite value.
- R2: The output equals the single-precision value of the input, narrowed to the target. This holds for every pair of formats, including bfloat16 to half.
- R3: Widening to single precision is exact for every source, including half subnormals (half 0x0001 gives 0x33800000).
- R4: Narrowing rounds to nearest, ties to even. A tie that falls on an even kept value stays put, and a tie on an odd kept value rounds up.
- R5: A finite value beyond the target's range becomes the largest finite magnitude with the input's sign. For half this is 0x7BFF; for the 4-exponent-bit 8-bit layout it is 0x7F. An infinity stays infinite in bfloat16, half and single, and saturates with its sign in the 8-bit layouts.
- R6: Results below the target's smallest normal magnitude are produced as subnormals. A single-precision 2^-24 becomes half 0x0001.
- R7: A NaN input produces a positive canonical quiet NaN in bfloat16, half and single: all-ones exponent with only the top fraction bit set (0x7FC0, 0x7E00, 0x7FC00000). In the 8-bit layouts it produces the positive saturated maximum.
- R8: A source or destination code outside the R1 set raises the error output, and the output word is zero.
- R9: Input bits above the source width are ignored. The output word's bits above the target width are zero, and the sign sits at bit E+M.
- R10: The result appears two clock edges after acceptance, and one element can be accepted every cycle. While the output is not taken it holds steady, and `in_ready` falls once both stages are full. No element is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input element present |
| in_ready | output | 1 | Converter can take an element this cycle |
| in_src_fmt | input | 8 | Source format code |
| in_dst_fmt | input | 8 | Destination format code |
| in_word | input | 32 | Source element in the low bits |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_word | output | 32 | Converted element, zero-extended |
| out_err | output | 1 | Unsupported format code seen |

## Verification
On every cycle, the assertions cover the handshake properties and the shape of each result. Both stages must hold their contents under backpressure. An erroneous result must read as zero. Bits above the target width must stay clear. A finite input must never leave a bfloat16 or half result with an all-ones exponent, which catches missing saturation. The numeric correctness of widening, tie-breaking, subnormal generation, NaN canonicalisation and the two-hop route can only be shown by the bench's directed scenarios. Those scenarios compare exact bit patterns worked out from the format definitions.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    localparam int HUB_W    = 32;
    localparam int HUB_EW   = 8;
    localparam int HUB_MW   = 23;
    localparam int HUB_BIAS = (1 << (HUB_EW - 1)) - 1;
    localparam int CODE_W   = 8;

    localparam logic [CODE_W-1:0] CODE_BF16   = 8'h06;
    localparam logic [CODE_W-1:0] CODE_HALF   = 8'h07;
    localparam logic [CODE_W-1:0] CODE_SINGLE = 8'h0A;
    localparam logic [CODE_W-1:0] CODE_F8E3   = 8'h0D;
    localparam logic [CODE_W-1:0] CODE_F8E4   = 8'h0E;
    localparam logic [CODE_W-1:0] CODE_F8E5   = 8'h0F;
    localparam logic [CODE_W-1:0] CODE_F8E2   = 8'h11;

    // format descriptor: legality, hub identity, special codes, field widths
    typedef struct packed {
        logic       ok;
        logic       hub;
        logic       ieee;
        logic [3:0] ew;
        logic [4:0] mw;
    } fmt_desc_t;

    // element on its way between the two stages
    typedef struct packed {
        logic [HUB_W-1:0] word;
        fmt_desc_t        dst;
        logic             err;
    } hub_elem_t;

    function automatic fmt_desc_t decode_fmt(logic [CODE_W-1:0] code);
        fmt_desc_t d;
        case (code)
            CODE_BF16:   d = '{1'b1, 1'b0, 1'b1, 4'd8, 5'd7};
            CODE_HALF:   d = '{1'b1, 1'b0, 1'b1, 4'd5, 5'd10};
            CODE_SINGLE: d = '{1'b1, 1'b1, 1'b1, 4'd8, 5'd23};
            CODE_F8E3:   d = '{1'b1, 1'b0, 1'b0, 4'd3, 5'd4};
            CODE_F8E4:   d = '{1'b1, 1'b0, 1'b0, 4'd4, 5'd3};
            CODE_F8E5:   d = '{1'b1, 1'b0, 1'b0, 4'd5, 5'd2};
            CODE_F8E2:   d = '{1'b1, 1'b0, 1'b0, 4'd2, 5'd5};
            default:     d = '0;
        endcase
        return d;
    endfunction

    // exact widening of any supported source into single precision
    function automatic logic [HUB_W-1:0] widen_to_hub(logic [HUB_W-1:0] x, fmt_desc_t f);
        int ew, mw, bias, lead, e32;
        logic [HUB_W-1:0] mant, ex, r;
        ew   = int'(f.ew);
        mw   = int'(f.mw);
        bias = (1 << (ew - 1)) - 1;
        mant = x & ((32'd1 << mw) - 32'd1);
        ex   = (x >> mw) & ((32'd1 << ew) - 32'd1);
        r    = ((x >> (ew + mw)) & 32'd1) << (HUB_W - 1);
        if (f.hub) begin
            r = x;
        end else if (f.ieee && ex == ((32'd1 << ew) - 32'd1)) begin
            r = (mant == '0) ? (r | 32'h7F80_0000) : 32'h7FC0_0000;
        end else if (ex == '0) begin
            if (mant != '0) begin
                lead = 0;
                for (int i = 0; i < HUB_MW; i++)
                    if (i < mw && mant[i]) lead = i;
                e32 = lead + 1 - bias - mw + HUB_BIAS;
                r = r | (32'(e32) << HUB_MW)
                      | ((mant << (HUB_MW - lead)) & 32'h007F_FFFF);
            end
        end else begin
            e32 = int'(ex) - bias + HUB_BIAS;
            r = r | (32'(e32) << HUB_MW) | (mant << (HUB_MW - mw));
        end
        return r;
    endfunction

    // single precision to target: nearest-even rounding, saturation, subnormals
    function automatic logic [HUB_W-1:0] narrow_from_hub(logic [HUB_W-1:0] w, fmt_desc_t f);
        int ew, mw, bias, ue, te, sh, base;
        logic [63:0] sig, kept, q, enc, maxenc, inf_c, nan_c, sgn;
        logic        guard, sticky;
        ew     = int'(f.ew);
        mw     = int'(f.mw);
        bias   = (1 << (ew - 1)) - 1;
        inf_c  = ((64'd1 << ew) - 64'd1) << mw;
        nan_c  = inf_c | (64'd1 << (mw - 1));
        maxenc = f.ieee ? ((((64'd1 << ew) - 64'd2) << mw) | ((64'd1 << mw) - 64'd1))
                        : ((((64'd1 << ew) - 64'd1) << mw) | ((64'd1 << mw) - 64'd1));
        sgn    = {63'd0, w[HUB_W-1]} << (ew + mw);
        if (w[30:23] == 8'hFF) begin
            if (w[22:0] != '0) enc = f.ieee ? nan_c : maxenc;
            else               enc = (f.ieee ? inf_c : maxenc) | sgn;
        end else if (f.hub) begin
            enc = {32'd0, w};
        end else begin
            sig  = {40'd0, (w[30:23] != 8'd0), w[22:0]};
            ue   = ((w[30:23] == 8'd0) ? 1 : int'(w[30:23])) - HUB_BIAS;
            te   = ue + bias;
            sh   = HUB_MW - mw + ((te < 1) ? (1 - te) : 0);
            if (sh > 40) sh = 40;
            kept   = sig >> sh;
            guard  = sig[sh-1];
            sticky = |(sig & ((64'd1 << (sh - 1)) - 64'd1));
            q      = kept + {63'd0, guard & (sticky | kept[0])};
            base   = (te >= 1) ? (te - 1) : 0;
            enc    = (64'(base) << mw) + q;
            if (enc > maxenc) enc = maxenc;
            enc    = enc | sgn;
        end
        return enc[HUB_W-1:0];
    endfunction

endpackage

// File: rtl/fpx_widen_stage.sv
module fpx_widen_stage
    import fpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [CODE_W-1:0] src_code,
    input  logic [CODE_W-1:0] dst_code,
    input  logic [HUB_W-1:0]  in_word,
    output logic              s_valid,
    input  logic              s_ready,
    output hub_elem_t         s_data
);
    fmt_desc_t src_d, dst_d;
    hub_elem_t nxt;

    always_comb begin
        src_d    = decode_fmt(src_code);
        dst_d    = decode_fmt(dst_code);
        nxt.err  = !(src_d.ok && dst_d.ok);
        nxt.dst  = dst_d;
        nxt.word = nxt.err ? '0 : widen_to_hub(in_word, src_d);
    end

    assign in_ready = !s_valid || s_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_valid <= 1'b0;
            s_data  <= '0;
        end else if (in_ready) begin
            s_valid <= in_valid;
            if (in_valid) s_data <= nxt;
        end
    end

    // R10: a stalled hub element neither vanishes nor changes
    p_stage_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (s_valid && !s_ready) |=> (s_valid && $stable(s_data)));

endmodule

// File: rtl/fpx_narrow_stage.sv
module fpx_narrow_stage
    import fpx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             s_valid,
    output logic             s_ready,
    input  hub_elem_t        s_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [HUB_W-1:0] out_word,
    output logic             out_err
);
    fmt_desc_t        o_dst;
    logic [HUB_W-1:0] nxt_word;
    logic [HUB_W-1:0] o_exp_field;
    logic [HUB_W-1:0] o_exp_ones;
    logic             take_finite_ieee;

    assign nxt_word = s_data.err ? '0 : narrow_from_hub(s_data.word, s_data.dst);
    assign s_ready  = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_word  <= '0;
            out_err   <= 1'b0;
            o_dst     <= '0;
        end else if (s_ready) begin
            out_valid <= s_valid;
            if (s_valid) begin
                out_word <= nxt_word;
                out_err  <= s_data.err;
                o_dst    <= s_data.dst;
            end
        end
    end

    // observation helpers for the checks below
    assign o_exp_ones  = (32'd1 << 32'(o_dst.ew)) - 32'd1;
    assign o_exp_field = (out_word >> 32'(o_dst.mw)) & o_exp_ones;
    assign take_finite_ieee = s_valid && s_ready && !s_data.err &&
                              (s_data.word[30:23] != 8'hFF) &&
                              s_data.dst.ieee && !s_data.dst.hub;

    // R10: result is held until the consumer takes it
    p_out_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_err)));

    // R8: an erroneous result reads as zero
    p_err_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_err) |-> (out_word == '0));

    // R9: nothing above the target's width
    p_upper_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_err) |->
        ((out_word >> (32'(o_dst.ew) + 32'(o_dst.mw) + 32'd1)) == '0));

    // R5: finite inputs never land on an infinity/NaN code of a narrow IEEE target
    p_sat_finite_r5: assert property (@(posedge clk) disable iff (rst)
        take_finite_ieee |=> (o_exp_field != o_exp_ones));

endmodule

// File: rtl/fpx_convert.sv
module fpx_convert
    import fpx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [7:0]  in_src_fmt,
    input  logic [7:0]  in_dst_fmt,
    input  logic [31:0] in_word,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_word,
    output logic        out_err
);
    logic      mid_valid;
    logic      mid_ready;
    hub_elem_t mid_data;

    fpx_widen_stage u_widen (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .src_code (in_src_fmt),
        .dst_code (in_dst_fmt),
        .in_word  (in_word),
        .s_valid  (mid_valid),
        .s_ready  (mid_ready),
        .s_data   (mid_data)
    );

    fpx_narrow_stage u_narrow (
        .clk       (clk),
        .rst       (rst),
        .s_valid   (mid_valid),
        .s_ready   (mid_ready),
        .s_data    (mid_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_word  (out_word),
        .out_err   (out_err)
    );

    // R10: input stalls only when a result is already waiting downstream
    p_stall_cause_r10: assert property (@(posedge clk) disable iff (rst)
        !in_ready |-> out_valid);

endmodule

// File: tb/test_fpx_convert.sv
module test_fpx_convert;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_src_fmt = 8'h0;
    logic [7:0]  in_dst_fmt = 8'h0;
    logic [31:0] in_word = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_word;
    logic        out_err;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    fpx_convert i_fpx_convert (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_src_fmt(in_src_fmt), .in_dst_fmt(in_dst_fmt), .in_word(in_word),
        .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
        .out_err(out_err)
    );

    localparam logic [7:0] BF = 8'h06, HF = 8'h07, SP = 8'h0A,
                           E3 = 8'h0D, E4 = 8'h0E, E5 = 8'h0F, E2 = 8'h11;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one element through an idle pipeline; result checked two edges later
    task automatic conv(string req, logic [7:0] s, logic [7:0] d,
                        logic [31:0] x, logic [31:0] exp, logic exp_err);
        @(negedge clk);
        in_src_fmt = s; in_dst_fmt = d; in_word = x; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk({req, " valid"}, {31'd0, out_valid}, 32'd1);
        chk({req, " word"}, out_word, exp);
        chk({req, " err"}, {31'd0, out_err}, {31'd0, exp_err});
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R10 reset out_valid", {31'd0, out_valid}, 32'd0);
        chk("R10 reset in_ready", {31'd0, in_ready}, 32'd1);
    endtask

    task automatic t_widen;
        conv("R3 half one",          HF, SP, 32'h0000_3C00, 32'h3F80_0000, 1'b0);
        conv("R3 half subnormal",    HF, SP, 32'h0000_0001, 32'h3380_0000, 1'b0);
        conv("R1 e3 all-ones exp",   E3, SP, 32'h0000_007F, 32'h41F8_0000, 1'b0);
        conv("R1 e2 top value",      E2, SP, 32'h0000_003F, 32'h3FFC_0000, 1'b0);
        conv("R1 e4 one",            E4, SP, 32'h0000_0038, 32'h3F80_0000, 1'b0);
    endtask

    task automatic t_two_hop;
        conv("R2 bf16 to half",      BF, HF, 32'h0000_3F80, 32'h0000_3C00, 1'b0);
        conv("R2 e5 to half",        E5, HF, 32'h0000_003C, 32'h0000_3C00, 1'b0);
        conv("R2 bf16 big to half",  BF, HF, 32'h0000_4780, 32'h0000_7BFF, 1'b0);
    endtask

    task automatic t_round;
        conv("R4 tie even stays",    SP, BF, 32'h3F80_8000, 32'h0000_3F80, 1'b0);
        conv("R4 tie odd up",        SP, BF, 32'h3F81_8000, 32'h0000_3F82, 1'b0);
        conv("R4 above half up",     SP, BF, 32'h3F80_8001, 32'h0000_3F81, 1'b0);
    endtask

    task automatic t_saturate;
        conv("R5 big to half",       SP, HF, 32'h5015_02F9, 32'h0000_7BFF, 1'b0);
        conv("R5 big to e4",         SP, E4, 32'h5015_02F9, 32'h0000_007F, 1'b0);
        conv("R5 neg big to e4",     SP, E4, 32'hD015_02F9, 32'h0000_00FF, 1'b0);
        conv("R5 neg inf kept",      HF, SP, 32'h0000_FC00, 32'hFF80_0000, 1'b0);
        conv("R5 neg inf to e4",     HF, E4, 32'h0000_FC00, 32'h0000_00FF, 1'b0);
    endtask

    task automatic t_subnormal;
        conv("R6 half min sub",      SP, HF, 32'h3380_0000, 32'h0000_0001, 1'b0);
        conv("R6 e4 min sub",        SP, E4, 32'h3B00_0000, 32'h0000_0001, 1'b0);
        conv("R6 half sub tie zero", SP, HF, 32'h3300_0000, 32'h0000_0000, 1'b0);
    endtask

    task automatic t_nan;
        conv("R7 nan to half",       SP, HF, 32'h7FA0_0000, 32'h0000_7E00, 1'b0);
        conv("R7 nan to bf16",       SP, BF, 32'h7FA0_0000, 32'h0000_7FC0, 1'b0);
        conv("R7 nan to single",     SP, SP, 32'hFFA0_0001, 32'h7FC0_0000, 1'b0);
        conv("R7 nan to e5",         SP, E5, 32'h7FA0_0000, 32'h0000_007F, 1'b0);
        conv("R7 bf16 nan widen",    BF, SP, 32'h0000_FFC1, 32'h7FC0_0000, 1'b0);
    endtask

    task automatic t_error;
        conv("R8 bad source",        8'h08, SP, 32'h3F80_0000, 32'h0000_0000, 1'b1);
        conv("R8 bad destination",   HF, 8'h10, 32'h0000_3C00, 32'h0000_0000, 1'b1);
    endtask

    task automatic t_upper;
        conv("R9 junk above bf16",   BF, HF, 32'hABCD_3F80, 32'h0000_3C00, 1'b0);
        conv("R9 neg e3 sign bit",   SP, E3, 32'hBF80_0000, 32'h0000_00B0, 1'b0);
    endtask

    task automatic t_stream;
        @(negedge clk);
        out_ready = 1'b0;
        in_src_fmt = HF; in_dst_fmt = SP; in_word = 32'h0000_3C00; in_valid = 1'b1;
        @(negedge clk);
        in_word = 32'h0000_4000;
        @(negedge clk);
        chk("R10 full stall in_ready", {31'd0, in_ready}, 32'd0);
        chk("R10 first out", out_word, 32'h3F80_0000);
        in_word = 32'h0000_C000;
        @(negedge clk);
        chk("R10 held out", out_word, 32'h3F80_0000);
        chk("R10 held valid", {31'd0, out_valid}, 32'd1);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10 second out", out_word, 32'h4000_0000);
        @(negedge clk);
        chk("R10 third out", out_word, 32'hC000_0000);
        @(negedge clk);
        chk("R10 drained", {31'd0, out_valid}, 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_widen();
        t_two_hop();
        t_round();
        t_saturate();
        t_subnormal();
        t_nan();
        t_error();
        t_upper();
        t_stream();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule